// File: doc/BRIEF.md
# System Timer Frame Pair

This block is a system timer that sits on a simple register bus. It holds one 64-bit count that rises by one every clock, and two compare timers built on that count. The physical timer compares the count itself. The virtual timer compares the count minus a programmable 64-bit offset. Each timer drives a level interrupt whose state software can enable, mask and observe.

The bus view spans two adjacent 4 KiB pages. The lower page is a control frame. It holds the tick frequency, a feature word and the writable virtual offset. The upper page is a timer frame. It holds both counts, both compare values, both down-count views and both control words, plus read-only copies of the frequency and the offset. Every 64-bit quantity can be reached in two ways: as two 32-bit halves, where a write to one half keeps the other half, or as one 8-byte access at the address of the low half.

A request is accepted on any cycle that `bus_valid` is high. The response comes back exactly one cycle later and carries the register contents from before that request's write.

Top module: `stf_top`

## Requirements
- R1: After reset the count is zero and rises by exactly one each clock. In the upper page it reads at 0x1000 (bits 31:0) and 0x1004 (bits 63:32), and as one 8-byte read at 0x1000.
- R2: A request with `bus_size` 0 or 1, or with an address at or above 0x2000, returns `rsp_err`=1 with zero data and changes no state. Size code 2 means 4 bytes and size code 3 means 8 bytes.
- R3: Every request gets `rsp_valid` in the next cycle, and there is no response without a request. A read returns the value held before any write made in the same cycle. A write returns zero data.
- R4: The feature word at 0x008 reads 0x3. The frequency parameter reads at 0x000 and at 0x1010. Reads of 0x004, 0x040 and 0x1014 return zero. Writes to 0x000, 0x004, 0x008 and 0x040 change nothing.
- R5: The virtual offset sits in the lower page at 0x080 (low half) and 0x084 (high half). A 4-byte write replaces only its own half. An 8-byte write at 0x080 replaces all 64 bits.
- R6: The upper page returns the virtual offset at 0x1080, 0x1084 and as 8 bytes at 0x1080. Writes at those addresses are ignored.
- R7: The virtual count equals the count minus the virtual offset, modulo 2^64. It reads at 0x1008 and 0x100C, and as 8 bytes at 0x1008.
- R8: The physical compare value sits at 0x1020/0x1024 and the virtual one at 0x1030/0x1034. A 4-byte write merges into one half. An 8-byte access at the low address reads or writes the whole value.
- R9: A 4-byte write of the down-count view (physical 0x1028, virtual 0x1038) sets compare = own count + the sign-extended written value. A read of the view returns bits 31:0 of compare minus own count.
- R10: The control words (physical 0x102C, virtual 0x103C) hold enable in bit 0 and mask in bit 1. Bit 2 is read-only status, which is 1 when the timer's own count is at or above its compare value.
- R11: `irq_phys` and `irq_virt` are each high exactly when that timer has enable=1, mask=0 and status=1. They follow the state without a delay.
- R12: An 8-byte access to a down-count view or a control word, or any access to an unlisted offset inside the two pages, reads zero, ignores the write and gives no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address relative to the block base |
| bus_size | input | 2 | Size code; 2 = 4 bytes, 3 = 8 bytes |
| bus_wdata | input | 64 | Write data, 4-byte writes use bits 31:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Illegal size or address |
| rsp_rdata | output | 64 | Read data |
| irq_phys | output | 1 | Physical timer level interrupt |
| irq_virt | output | 1 | Virtual timer level interrupt |

## Verification
Two things can land in the same cycle: a write to a compare value, a down-count view or the offset, and the count stepping across the compare value. The first moves the target and the second moves the count, and both feed the same status bit and interrupt. The bench provokes the collision by writing down-count values of 0, 1 and small negative numbers, by writing the offset while a virtual compare is close, and by toggling enable just as the count reaches the target. Randomly drawn small down-count values then repeat the collision many times. After every clock a reference model that tracks the count judges both interrupt levels, and it also checks each read of the status bit and the down-count view.

// File: rtl/stf_pkg.sv
package stf_pkg;

    localparam int PAGE_AW = 12;
    localparam int CNT_W   = 64;
    localparam int HALF_W  = 32;
    localparam logic [HALF_W-1:0] FEATURE_WORD = 32'h3;

    // lower page
    localparam logic [PAGE_AW-1:0] OFS_FREQ    = 12'h000;
    localparam logic [PAGE_AW-1:0] OFS_NSACC   = 12'h004;
    localparam logic [PAGE_AW-1:0] OFS_FEAT    = 12'h008;
    localparam logic [PAGE_AW-1:0] OFS_ACCCTL  = 12'h040;
    localparam logic [PAGE_AW-1:0] OFS_VOFF_LO = 12'h080;
    localparam logic [PAGE_AW-1:0] OFS_VOFF_HI = 12'h084;
    // upper page
    localparam logic [PAGE_AW-1:0] OFS_PCNT_LO = 12'h000;
    localparam logic [PAGE_AW-1:0] OFS_PCNT_HI = 12'h004;
    localparam logic [PAGE_AW-1:0] OFS_VCNT_LO = 12'h008;
    localparam logic [PAGE_AW-1:0] OFS_VCNT_HI = 12'h00C;
    localparam logic [PAGE_AW-1:0] OFS_TFREQ   = 12'h010;
    localparam logic [PAGE_AW-1:0] OFS_USRACC  = 12'h014;
    localparam logic [PAGE_AW-1:0] OFS_PCMP_LO = 12'h020;
    localparam logic [PAGE_AW-1:0] OFS_PCMP_HI = 12'h024;
    localparam logic [PAGE_AW-1:0] OFS_PDOWN   = 12'h028;
    localparam logic [PAGE_AW-1:0] OFS_PCTRL   = 12'h02C;
    localparam logic [PAGE_AW-1:0] OFS_VCMP_LO = 12'h030;
    localparam logic [PAGE_AW-1:0] OFS_VCMP_HI = 12'h034;
    localparam logic [PAGE_AW-1:0] OFS_VDOWN   = 12'h038;
    localparam logic [PAGE_AW-1:0] OFS_VCTRL   = 12'h03C;

    typedef enum logic [1:0] {SZ_B1 = 2'd0, SZ_B2 = 2'd1, SZ_B4 = 2'd2, SZ_B8 = 2'd3} acc_size_e;

    typedef enum logic [3:0] {
        K_NONE, K_FREQ, K_FEAT,
        K_OFS_LO, K_OFS_HI, K_OFS_W,
        K_CNT_LO, K_CNT_HI, K_CNT_W,
        K_CMP_LO, K_CMP_HI, K_CMP_W,
        K_DOWN, K_CTRL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e kind;
        logic      virt;
        logic      wr_ok;
        logic      err;
    } dec_t;

    typedef struct packed {
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_full;
        logic down;
        logic ctrl;
    } tmr_wr_t;

    function automatic logic [CNT_W-1:0] merge_half(input logic [CNT_W-1:0] old,
                                                    input logic [HALF_W-1:0] part,
                                                    input logic hi);
        logic [CNT_W-1:0] r;
        r = old;
        if (hi) r[CNT_W-1:HALF_W] = part;
        else    r[HALF_W-1:0]     = part;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] sext_half(input logic [HALF_W-1:0] v);
        return {{(CNT_W-HALF_W){v[HALF_W-1]}}, v};
    endfunction

    function automatic dec_t decode(input logic in_range, input logic page,
                                    input logic [PAGE_AW-1:0] ofs, input acc_size_e sz);
        dec_t d;
        d = '{kind: K_NONE, virt: 1'b0, wr_ok: 1'b0, err: 1'b0};
        if (!in_range || (sz == SZ_B1) || (sz == SZ_B2)) begin
            d.err = 1'b1;
        end else if (!page) begin
            if (sz == SZ_B4) begin
                case (ofs)
                    OFS_FREQ:    d.kind = K_FREQ;
                    OFS_FEAT:    d.kind = K_FEAT;
                    OFS_VOFF_LO: begin d.kind = K_OFS_LO; d.wr_ok = 1'b1; end
                    OFS_VOFF_HI: begin d.kind = K_OFS_HI; d.wr_ok = 1'b1; end
                    default:     d.kind = K_NONE;
                endcase
            end else begin
                if (ofs == OFS_VOFF_LO) begin
                    d.kind  = K_OFS_W;
                    d.wr_ok = 1'b1;
                end
            end
        end else begin
            if (sz == SZ_B4) begin
                case (ofs)
                    OFS_PCNT_LO: d.kind = K_CNT_LO;
                    OFS_PCNT_HI: d.kind = K_CNT_HI;
                    OFS_VCNT_LO: begin d.kind = K_CNT_LO; d.virt = 1'b1; end
                    OFS_VCNT_HI: begin d.kind = K_CNT_HI; d.virt = 1'b1; end
                    OFS_TFREQ:   d.kind = K_FREQ;
                    OFS_VOFF_LO: d.kind = K_OFS_LO;
                    OFS_VOFF_HI: d.kind = K_OFS_HI;
                    OFS_PCMP_LO: begin d.kind = K_CMP_LO; d.wr_ok = 1'b1; end
                    OFS_PCMP_HI: begin d.kind = K_CMP_HI; d.wr_ok = 1'b1; end
                    OFS_PDOWN:   begin d.kind = K_DOWN;   d.wr_ok = 1'b1; end
                    OFS_PCTRL:   begin d.kind = K_CTRL;   d.wr_ok = 1'b1; end
                    OFS_VCMP_LO: begin d.kind = K_CMP_LO; d.wr_ok = 1'b1; d.virt = 1'b1; end
                    OFS_VCMP_HI: begin d.kind = K_CMP_HI; d.wr_ok = 1'b1; d.virt = 1'b1; end
                    OFS_VDOWN:   begin d.kind = K_DOWN;   d.wr_ok = 1'b1; d.virt = 1'b1; end
                    OFS_VCTRL:   begin d.kind = K_CTRL;   d.wr_ok = 1'b1; d.virt = 1'b1; end
                    default:     d.kind = K_NONE;
                endcase
            end else begin
                case (ofs)
                    OFS_PCNT_LO: d.kind = K_CNT_W;
                    OFS_VCNT_LO: begin d.kind = K_CNT_W; d.virt = 1'b1; end
                    OFS_VOFF_LO: d.kind = K_OFS_W;
                    OFS_PCMP_LO: begin d.kind = K_CMP_W; d.wr_ok = 1'b1; end
                    OFS_VCMP_LO: begin d.kind = K_CMP_W; d.wr_ok = 1'b1; d.virt = 1'b1; end
                    default:     d.kind = K_NONE;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/stf_counter.sv
module stf_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/stf_timer.sv
module stf_timer
    import stf_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      count,
    input  tmr_wr_t           wr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      cmp,
    output logic [HALF_W-1:0] ctrl_rd,
    output logic [HALF_W-1:0] down_rd,
    output logic              irq
);
    logic en_q, mask_q, status;
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp    <= '0;
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (wr.cmp_full)    cmp <= wdata;
            else if (wr.cmp_lo) cmp <= merge_half(cmp, wdata[HALF_W-1:0], 1'b0);
            else if (wr.cmp_hi) cmp <= merge_half(cmp, wdata[HALF_W-1:0], 1'b1);
            else if (wr.down)   cmp <= count + sext_half(wdata[HALF_W-1:0]);
            if (wr.ctrl) begin
                en_q   <= wdata[0];
                mask_q <= wdata[1];
            end
        end
    end

    always_comb begin
        status  = (count >= cmp);
        remain  = cmp - count;
        down_rd = remain[HALF_W-1:0];
        ctrl_rd = {{(HALF_W-3){1'b0}}, status, mask_q, en_q};
        irq     = en_q & ~mask_q & status;
    end
endmodule

// File: rtl/stf_top.sv
module stf_top
    import stf_pkg::*;
#(
    parameter int          BUS_AW  = 16,
    parameter logic [31:0] FREQ_HZ = 32'd250_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [63:0]       bus_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              irq_phys,
    output logic              irq_virt
);
    localparam int NTMR   = 2;
    localparam int PAGE_B = PAGE_AW;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] voff_q;
    logic             in_range;
    dec_t             dec;
    logic             wr_fire;
    logic [CNT_W-1:0] rdata_d;

    logic [CNT_W-1:0]  tmr_count [NTMR];
    logic [CNT_W-1:0]  tmr_cmp   [NTMR];
    logic [HALF_W-1:0] tmr_ctrl  [NTMR];
    logic [HALF_W-1:0] tmr_down  [NTMR];
    logic              tmr_irq   [NTMR];
    tmr_wr_t           tmr_wr    [NTMR];

    stf_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .count (cnt_q)
    );

    assign in_range = ~|bus_addr[BUS_AW-1:PAGE_B+1];
    assign dec      = decode(in_range, bus_addr[PAGE_B], bus_addr[PAGE_B-1:0], acc_size_e'(bus_size));
    assign wr_fire  = bus_valid & bus_write & dec.wr_ok & ~dec.err;

    always_ff @(posedge clk) begin
        if (rst) begin
            voff_q <= '0;
        end else if (wr_fire) begin
            case (dec.kind)
                K_OFS_LO: voff_q <= merge_half(voff_q, bus_wdata[HALF_W-1:0], 1'b0);
                K_OFS_HI: voff_q <= merge_half(voff_q, bus_wdata[HALF_W-1:0], 1'b1);
                K_OFS_W:  voff_q <= bus_wdata;
                default:  voff_q <= voff_q;
            endcase
        end
    end

    assign tmr_count[0] = cnt_q;
    assign tmr_count[1] = cnt_q - voff_q;

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        logic sel;
        assign sel = wr_fire & (dec.virt == (t != 0));
        assign tmr_wr[t] = '{cmp_lo:   sel & (dec.kind == K_CMP_LO),
                             cmp_hi:   sel & (dec.kind == K_CMP_HI),
                             cmp_full: sel & (dec.kind == K_CMP_W),
                             down:     sel & (dec.kind == K_DOWN),
                             ctrl:     sel & (dec.kind == K_CTRL)};
        stf_timer #(.W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .count   (tmr_count[t]),
            .wr      (tmr_wr[t]),
            .wdata   (bus_wdata),
            .cmp     (tmr_cmp[t]),
            .ctrl_rd (tmr_ctrl[t]),
            .down_rd (tmr_down[t]),
            .irq     (tmr_irq[t])
        );
    end

    always_comb begin
        logic [CNT_W-1:0] c_sel, k_sel;
        c_sel   = dec.virt ? tmr_count[1] : tmr_count[0];
        k_sel   = dec.virt ? tmr_cmp[1]   : tmr_cmp[0];
        rdata_d = '0;
        case (dec.kind)
            K_FREQ:   rdata_d[HALF_W-1:0] = FREQ_HZ;
            K_FEAT:   rdata_d[HALF_W-1:0] = FEATURE_WORD;
            K_OFS_LO: rdata_d[HALF_W-1:0] = voff_q[HALF_W-1:0];
            K_OFS_HI: rdata_d[HALF_W-1:0] = voff_q[CNT_W-1:HALF_W];
            K_OFS_W:  rdata_d = voff_q;
            K_CNT_LO: rdata_d[HALF_W-1:0] = c_sel[HALF_W-1:0];
            K_CNT_HI: rdata_d[HALF_W-1:0] = c_sel[CNT_W-1:HALF_W];
            K_CNT_W:  rdata_d = c_sel;
            K_CMP_LO: rdata_d[HALF_W-1:0] = k_sel[HALF_W-1:0];
            K_CMP_HI: rdata_d[HALF_W-1:0] = k_sel[CNT_W-1:HALF_W];
            K_CMP_W:  rdata_d = k_sel;
            K_DOWN:   rdata_d[HALF_W-1:0] = dec.virt ? tmr_down[1] : tmr_down[0];
            K_CTRL:   rdata_d[HALF_W-1:0] = dec.virt ? tmr_ctrl[1] : tmr_ctrl[0];
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= bus_valid;
            rsp_err   <= bus_valid & dec.err;
            rsp_rdata <= (bus_valid & ~bus_write & ~dec.err) ? rdata_d : '0;
        end
    end

    assign irq_phys = tmr_irq[0];
    assign irq_virt = tmr_irq[1];
endmodule

// File: rtl/stf_checker.sv
module stf_checker
    import stf_pkg::*;
#(
    parameter int BUS_AW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              irq_phys,
    input logic              irq_virt,
    input logic [63:0]       count,
    input logic [63:0]       voff,
    input logic [63:0]       pcmp,
    input logic [63:0]       vcmp
);
    a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> rsp_valid);
    a_r3_no_stray_rsp: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !rsp_valid);
    a_r1_count_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 64'd1);
    a_r2_bad_size_err: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_size[1]) |=> (rsp_err && rsp_rdata == 64'd0));
    a_r6_offset_only_lower_page: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && bus_write && bus_addr[BUS_AW-1:PAGE_AW] == '0) |=> $stable(voff));
    a_r4_feature_word: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_size == 2'd2 && bus_addr == BUS_AW'(OFS_FEAT))
        |=> rsp_rdata == 64'h3);
    a_r11_phys_irq_reached: assert property (@(posedge clk) disable iff (rst)
        irq_phys |-> count >= pcmp);
    a_r11_virt_irq_reached: assert property (@(posedge clk) disable iff (rst)
        irq_virt |-> (count - voff) >= vcmp);
endmodule

bind stf_top stf_checker #(.BUS_AW(BUS_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .irq_phys  (irq_phys),
    .irq_virt  (irq_virt),
    .count     (cnt_q),
    .voff      (voff_q),
    .pcmp      (tmr_cmp[0]),
    .vcmp      (tmr_cmp[1])
);

// File: tb/tb_stf_top.sv
module tb_stf_top;
    localparam logic [31:0] FREQ = 32'd250_000_000;

    localparam logic [15:0] A_FREQ = 16'h0000, A_NSACC = 16'h0004, A_FEAT = 16'h0008,
                            A_ACC = 16'h0040, A_OFLO = 16'h0080, A_OFHI = 16'h0084;
    localparam logic [15:0] A_PCLO = 16'h1000, A_PCHI = 16'h1004, A_VCLO = 16'h1008,
                            A_VCHI = 16'h100C, A_TFRQ = 16'h1010, A_UACC = 16'h1014,
                            A_TOLO = 16'h1080, A_TOHI = 16'h1084,
                            A_PKLO = 16'h1020, A_PKHI = 16'h1024, A_PDN = 16'h1028,
                            A_PCTL = 16'h102C, A_VKLO = 16'h1030, A_VKHI = 16'h1034,
                            A_VDN = 16'h1038, A_VCTL = 16'h103C;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [63:0] bus_wdata = '0;
    logic rsp_valid, rsp_err, irq_phys, irq_virt;
    logic [63:0] rsp_rdata;

    always #2 clk = ~clk;

    stf_top dut (.clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
                 .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
                 .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
                 .irq_phys(irq_phys), .irq_virt(irq_virt));

    logic [63:0] tbc;
    always @(posedge clk) begin
        if (rst) tbc <= '0;
        else     tbc <= tbc + 64'd1;
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [63:0] m_voff, n_voff;
    logic [63:0] m_cmp [2];
    logic [63:0] n_cmp [2];
    logic [1:0]  m_ctl [2];
    logic [1:0]  n_ctl [2];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] own_cnt(input int t);
        return (t != 0) ? tbc - m_voff : tbc;
    endfunction

    function automatic logic exp_irq(input int t);
        return m_ctl[t][0] & ~m_ctl[t][1] & (own_cnt(t) >= m_cmp[t]);
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic [1:0] sz);
        if (!sz[1] || a >= 16'h2000) return "R2";
        case (a)
            A_FREQ, A_NSACC, A_FEAT, A_ACC, A_TFRQ, A_UACC: return "R4";
            A_OFLO, A_OFHI: return "R5";
            A_TOLO, A_TOHI: return "R6";
            A_PCLO, A_PCHI: return "R1";
            A_VCLO, A_VCHI: return "R7";
            A_PKLO, A_PKHI, A_VKLO, A_VKHI: return "R8";
            A_PDN, A_VDN: return (sz == 2'd3) ? "R12" : "R9";
            A_PCTL, A_VCTL: return (sz == 2'd3) ? "R12" : "R10";
            default: return "R12";
        endcase
    endfunction

    // reference model: expected response and next state
    task automatic model(input logic w, input logic [15:0] a, input logic [1:0] sz,
                         input logic [63:0] wd, output logic [63:0] rd, output logic err);
        logic [63:0] v;
        n_voff = m_voff;
        for (int t = 0; t < 2; t++) begin n_cmp[t] = m_cmp[t]; n_ctl[t] = m_ctl[t]; end
        rd  = '0;
        err = (!sz[1]) || (a >= 16'h2000);
        if (err) return;
        v = '0;
        if (sz == 2'd2) begin
            case (a)
                A_FREQ, A_TFRQ: v = {32'd0, FREQ};
                A_FEAT: v = 64'h3;
                A_OFLO, A_TOLO: v = {32'd0, m_voff[31:0]};
                A_OFHI, A_TOHI: v = {32'd0, m_voff[63:32]};
                A_PCLO: v = {32'd0, own_cnt(0)[31:0]};
                A_PCHI: v = {32'd0, own_cnt(0)[63:32]};
                A_VCLO: v = {32'd0, own_cnt(1)[31:0]};
                A_VCHI: v = {32'd0, own_cnt(1)[63:32]};
                A_PKLO: v = {32'd0, m_cmp[0][31:0]};
                A_PKHI: v = {32'd0, m_cmp[0][63:32]};
                A_VKLO: v = {32'd0, m_cmp[1][31:0]};
                A_VKHI: v = {32'd0, m_cmp[1][63:32]};
                A_PDN:  v = {32'd0, 32'(m_cmp[0] - own_cnt(0))};
                A_VDN:  v = {32'd0, 32'(m_cmp[1] - own_cnt(1))};
                A_PCTL: v = {61'd0, own_cnt(0) >= m_cmp[0], m_ctl[0]};
                A_VCTL: v = {61'd0, own_cnt(1) >= m_cmp[1], m_ctl[1]};
                default: v = '0;
            endcase
            if (w) begin
                case (a)
                    A_OFLO: n_voff[31:0]  = wd[31:0];
                    A_OFHI: n_voff[63:32] = wd[31:0];
                    A_PKLO: n_cmp[0][31:0]  = wd[31:0];
                    A_PKHI: n_cmp[0][63:32] = wd[31:0];
                    A_VKLO: n_cmp[1][31:0]  = wd[31:0];
                    A_VKHI: n_cmp[1][63:32] = wd[31:0];
                    A_PDN:  n_cmp[0] = own_cnt(0) + sx(wd[31:0]);
                    A_VDN:  n_cmp[1] = own_cnt(1) + sx(wd[31:0]);
                    A_PCTL: n_ctl[0] = wd[1:0];
                    A_VCTL: n_ctl[1] = wd[1:0];
                    default: ;
                endcase
            end
        end else begin
            case (a)
                A_PCLO: v = own_cnt(0);
                A_VCLO: v = own_cnt(1);
                A_OFLO, A_TOLO: v = m_voff;
                A_PKLO: v = m_cmp[0];
                A_VKLO: v = m_cmp[1];
                default: v = '0;
            endcase
            if (w) begin
                case (a)
                    A_OFLO: n_voff = wd;
                    A_PKLO: n_cmp[0] = wd;
                    A_VKLO: n_cmp[1] = wd;
                    default: ;
                endcase
            end
        end
        rd = w ? 64'd0 : v;
    endtask

    task automatic check_irqs();
        check(irq_phys === exp_irq(0), "R11 phys irq", {63'd0, irq_phys}, {63'd0, exp_irq(0)});
        check(irq_virt === exp_irq(1), "R11 virt irq", {63'd0, irq_virt}, {63'd0, exp_irq(1)});
    endtask

    task automatic access(input logic w, input logic [15:0] a, input logic [1:0] sz,
                          input logic [63:0] wd, output logic [63:0] got);
        logic [63:0] erd;
        logic eerr;
        string tg;
        tg = tag_of(a, sz);
        model(w, a, sz, wd, erd, eerr);
        bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        m_voff = n_voff;
        for (int t = 0; t < 2; t++) begin m_cmp[t] = n_cmp[t]; m_ctl[t] = n_ctl[t]; end
        got = rsp_rdata;
        check(rsp_valid === 1'b1, "R3 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        check(rsp_err === eerr, {tg, " err"}, {63'd0, rsp_err}, {63'd0, eerr});
        check(rsp_rdata === erd, {tg, " data"}, rsp_rdata, erd);
        check_irqs();
    endtask

    task automatic rd(input logic [15:0] a, input logic [1:0] sz);
        logic [63:0] g;
        access(1'b0, a, sz, 64'd0, g);
    endtask

    task automatic wr(input logic [15:0] a, input logic [1:0] sz, input logic [63:0] d);
        logic [63:0] g;
        access(1'b1, a, sz, d, g);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(rsp_valid === 1'b0, "R3 idle", {63'd0, rsp_valid}, 64'd0);
            check_irqs();
        end
    endtask

    function automatic logic [15:0] pick_addr(input int k);
        case (k)
            0: return A_FREQ;  1: return A_NSACC; 2: return A_FEAT;  3: return A_ACC;
            4: return A_OFLO;  5: return A_OFHI;  6: return A_PCLO;  7: return A_PCHI;
            8: return A_VCLO;  9: return A_VCHI;  10: return A_TFRQ; 11: return A_UACC;
            12: return A_TOLO; 13: return A_TOHI; 14: return A_PKLO; 15: return A_PKHI;
            16: return A_PDN;  17: return A_PCTL; 18: return A_VKLO; 19: return A_VKHI;
            20: return A_VDN;  21: return A_VCTL; 22: return 16'h0200;
            default: return 16'h2000 + 16'($urandom % 256);
        endcase
    endfunction

    initial begin
        logic [63:0] g, snap;
        void'($urandom(32'd20240611));
        m_voff = '0;
        for (int t = 0; t < 2; t++) begin m_cmp[t] = '0; m_ctl[t] = '0; end
        repeat (5) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R3 reset state", {62'd0, rsp_valid, rsp_err}, 64'd0);
        check(irq_phys === 1'b0 && irq_virt === 1'b0, "R11 reset irq", {62'd0, irq_phys, irq_virt}, 64'd0);
        rst = 1'b0;
        idle(3);
        // R1 count
        rd(A_PCLO, 2'd2); rd(A_PCHI, 2'd2); rd(A_PCLO, 2'd3);
        // R4 identification and ignored writes
        rd(A_FEAT, 2'd2); rd(A_FREQ, 2'd2); rd(A_TFRQ, 2'd2); rd(A_NSACC, 2'd2); rd(A_ACC, 2'd2); rd(A_UACC, 2'd2);
        wr(A_FEAT, 2'd2, 64'hFFFF_FFFF); wr(A_FREQ, 2'd2, 64'h1234); wr(A_ACC, 2'd2, 64'h7); wr(A_NSACC, 2'd2, 64'h1);
        rd(A_FEAT, 2'd2); rd(A_FREQ, 2'd2); rd(A_NSACC, 2'd2); rd(A_ACC, 2'd2);
        // R5 offset halves and full write
        wr(A_OFLO, 2'd2, 64'hDEAD_0000_0000_0010);
        wr(A_OFHI, 2'd2, 64'h0000_0000_0000_0001);
        rd(A_OFLO, 2'd3); rd(A_OFHI, 2'd2);
        wr(A_OFLO, 2'd3, 64'h0000_0000_0000_0008);
        rd(A_OFLO, 2'd2); rd(A_OFHI, 2'd2);
        // R6 read-only copy in the upper page
        wr(A_TOLO, 2'd2, 64'h55); wr(A_TOHI, 2'd2, 64'h66); wr(A_TOLO, 2'd3, 64'h77);
        rd(A_TOLO, 2'd2); rd(A_TOLO, 2'd3); rd(A_OFLO, 2'd3);
        // R7 virtual count
        rd(A_VCLO, 2'd2); rd(A_VCHI, 2'd2); rd(A_VCLO, 2'd3);
        wr(A_OFLO, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0);
        rd(A_VCLO, 2'd3); rd(A_VCHI, 2'd2);
        // R8 compare halves
        wr(A_PKLO, 2'd3, 64'h1111_2222_3333_4444);
        wr(A_PKHI, 2'd2, 64'h9999_AAAA);
        rd(A_PKLO, 2'd3);
        wr(A_PKLO, 2'd2, 64'h5555);
        rd(A_PKLO, 2'd2); rd(A_PKHI, 2'd2);
        wr(A_VKLO, 2'd3, 64'h0123_4567_89AB_CDEF); rd(A_VKHI, 2'd2); rd(A_VKLO, 2'd3);
        // R9/R10/R11 count reaching the target while enabled
        wr(A_OFLO, 2'd3, 64'd0);
        wr(A_PCTL, 2'd2, 64'h1);
        wr(A_PDN, 2'd2, 64'd4);
        rd(A_PDN, 2'd2); rd(A_PCTL, 2'd2);
        idle(4);
        rd(A_PCTL, 2'd2); rd(A_PDN, 2'd2);
        wr(A_PCTL, 2'd2, 64'h3); idle(2);
        rd(A_PCTL, 2'd2);
        wr(A_PCTL, 2'd2, 64'h7); rd(A_PCTL, 2'd2);
        wr(A_PCTL, 2'd2, 64'h1);
        wr(A_PDN, 2'd2, 64'h0000_0000_FFFF_FFFE);
        rd(A_PDN, 2'd2);
        wr(A_PDN, 2'd2, 64'd0); idle(2);
        wr(A_PDN, 2'd2, 64'd1); idle(3);
        // virtual side: offset write near the target
        wr(A_VCTL, 2'd2, 64'h1);
        wr(A_VDN, 2'd2, 64'd3);
        wr(A_OFLO, 2'd2, 64'd2); idle(2);
        wr(A_OFLO, 2'd2, 64'd0); idle(3);
        rd(A_VCTL, 2'd2); rd(A_VDN, 2'd2);
        // R12 8-byte views and unlisted offsets
        snap = m_cmp[0];
        wr(A_PDN, 2'd3, 64'h10); rd(A_PDN, 2'd3); rd(A_PCTL, 2'd3);
        wr(A_PCTL, 2'd3, 64'h0); rd(A_PCTL, 2'd2);
        rd(A_PKLO, 2'd3);
        check(m_cmp[0] === snap, "R12 compare kept", m_cmp[0], snap);
        wr(16'h0300, 2'd2, 64'hF); rd(16'h0300, 2'd2); rd(16'h1F00, 2'd3); rd(A_PCHI, 2'd3);
        // R2 illegal size and range
        wr(A_OFLO, 2'd0, 64'hABCD); wr(A_PKLO, 2'd1, 64'h1); rd(A_FEAT, 2'd1);
        wr(16'h2080, 2'd2, 64'h9); rd(16'h4000, 2'd3);
        rd(A_OFLO, 2'd3); rd(A_PKLO, 2'd3);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [1:0]  sz;
            logic [63:0] d;
            logic        w;
            int          r;
            a = pick_addr(int'($urandom % 25));
            r = int'($urandom % 100);
            sz = (r < 78) ? 2'd2 : (r < 95) ? 2'd3 : 2'(r % 2);
            w = $urandom % 2;
            d = {$urandom, $urandom};
            if (a == A_PDN || a == A_VDN) d = 64'(sx(32'(int'($urandom % 24) - 6)));
            if (a == A_PCTL || a == A_VCTL) d = 64'($urandom % 8);
            if (a == A_OFLO || a == A_OFHI) d = 64'($urandom % 16);
            if (a == A_PKHI || a == A_VKHI) d = (($urandom % 4) == 0) ? d : 64'd0;
            access(w, a, sz, d, g);
            if (($urandom % 8) == 0) idle(1 + int'($urandom % 3));
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule